// File: doc/BRIEF.md
# Posted-Write Register Bridge

This block sits between a bus running on the interface clock and a timer register file running on a slower, unrelated functional clock. Five registers have a copy in the functional domain: control, counter, load, trigger and match. A bus write to one of them is held in a bus-side shadow register. A toggle handshake then carries the value across the clock boundary, with two-flop synchronizers in each direction. A per-register pending flag stays set from the accepting cycle until the handshake has returned. These flags can be read at a dedicated read-only offset.

Two write modes exist. In posted mode, which is the reset default, a write completes in the cycle it is presented. A second write to a register whose flag is still set is refused with a slave-error response, and the in-flight value is kept. A read of such a register also returns an error. In non-posted mode the bus is held off with ready low until the transfer has landed, and no error is ever returned. An interface-control register selects the mode and can start a soft reset, which is reported through a reset-done flag.

Top module: `posted_reg_bridge`

## Requirements
- R1: After reset, interface control (0x40) reads 0x4 (bit 2 = posted mode), the pending register (0x34) reads 0, system status (0x14) bit 0 reads 1, and every functional-side copy is 0.
- R2: In posted mode, a write to control 0x24, counter 0x28, load 0x2C, trigger 0x30 or match 0x38 is accepted in the cycle it is presented. It sets that register's pending bit at 0x34: control bit 0, counter bit 1, load bit 2, trigger bit 3, match bit 4.
- R3: A transferred value appears on the register's functional-side output. It comes with exactly one functional-clock strobe for that register. The pending bit then returns to 0.
- R4: In posted mode, a write to a register whose pending bit is set completes at once with err_o high. The value is dropped: no strobe is produced, and both the readback and the functional copy keep the earlier value.
- R5: In posted mode, a read of a synchronized register whose pending bit is set completes with err_o high.
- R6: With interface-control bit 2 cleared (non-posted), a write to a synchronized register holds ready_o low until the transfer has landed. It completes without error, and the pending register then reads 0.
- R7: The pending register is read-only, and writes to it are ignored. Writes to interface control set no pending bit.
- R8: Writing interface-control bit 1 starts a soft reset. System status bit 0 reads 0 for RST_CYCLES bus cycles and then 1, and interface control returns to 0x4.
- R9: Offset 0x3C returns capture_i. Unmapped offsets read 0.
- R10: A pending transfer on one register does not delay or refuse a posted write to another register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| fclk_i | input | 1 | Functional clock |
| req_i | input | 1 | Bus request, held until ready_o |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Transfer completes on this cycle when req_i is high |
| err_o | output | 1 | Slave-error response, valid with ready_o |
| rdata_o | output | DATA_W | Read data, valid with ready_o |
| capture_i | input | DATA_W | Capture value from the timer datapath |
| fregs_o | output | 5*DATA_W | Functional copies: control, counter, load, trigger, match, lowest slice first |
| fstb_o | output | 5 | One-cycle functional-clock strobe when a register copy updates |

## Verification
On every cycle, the assertions check the following. An error response happens only in posted mode and only together with ready. A non-posted write to a pending register is stalled. No transfer is launched while its channel is pending. A shadow value holds while its flag is set. A functional copy changes only with its strobe. The soft-reset window is held. Two things only the bench scenarios can show: that a dropped write really leaves the old value on both sides of the boundary, and the relation between pending bits, landed values and strobe counts across the asynchronous clocks.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
  localparam int NCH = 5;
  typedef enum int {CH_CTRL = 0, CH_CNT = 1, CH_LOAD = 2, CH_TRIG = 3, CH_MATCH = 4} chan_e;
  localparam logic [7:0] CH_OFS [NCH] = '{8'h24, 8'h28, 8'h2C, 8'h30, 8'h38};
  localparam logic [7:0] OFS_SYS  = 8'h14;
  localparam logic [7:0] OFS_PEND = 8'h34;
  localparam logic [7:0] OFS_CAP  = 8'h3C;
  localparam logic [7:0] OFS_IF   = 8'h40;
  localparam int IF_SRST_BIT   = 1;
  localparam int IF_POSTED_BIT = 2;
endpackage

// File: rtl/pwb_sync2.sv
`timescale 1ns/1ps
module pwb_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/pwb_chan.sv
`timescale 1ns/1ps
module pwb_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fclk_i,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pend_o,
  output logic [DATA_W-1:0] shadow_o,
  output logic [DATA_W-1:0] fdata_o,
  output logic              fstb_o
);
  logic              req_tgl_q, req_s, seen_q, ack_s, land, fstb_q;
  logic [DATA_W-1:0] shadow_q, fdata_q;

  // bus side: shadow is frozen while the toggle is in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_tgl_q <= 1'b0;
      shadow_q  <= '0;
    end else if (launch_i) begin
      req_tgl_q <= ~req_tgl_q;
      shadow_q  <= wdata_i;
    end
  end

  pwb_sync2 u_req_sync (.clk_i(fclk_i), .rst_ni(rst_ni), .d_i(req_tgl_q), .q_o(req_s));

  assign land = req_s ^ seen_q;

  always_ff @(posedge fclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      fstb_q  <= 1'b0;
      fdata_q <= '0;
    end else begin
      seen_q <= req_s;
      fstb_q <= land;
      if (land) fdata_q <= shadow_q;
    end
  end

  pwb_sync2 u_ack_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(seen_q), .q_o(ack_s));

  assign pend_o   = req_tgl_q ^ ack_s;
  assign shadow_o = shadow_q;
  assign fdata_o  = fdata_q;
  assign fstb_o   = fstb_q;

  AST_NO_LAUNCH_WHILE_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !pend_o); // R4
  AST_PEND_SETS_ON_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(launch_i)); // R2
  AST_SHADOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && $past(pend_o) |-> $stable(shadow_q)); // R4
  AST_FDATA_ONLY_ON_STB: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    !fstb_q |-> $stable(fdata_q)); // R3
endmodule

// File: rtl/pwb_soft_rst.sv
`timescale 1ns/1ps
module pwb_soft_rst #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = !busy_q;

  AST_RST_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i)); // R8
  AST_RST_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> busy_q); // R8
endmodule

// File: rtl/posted_reg_bridge.sv
`timescale 1ns/1ps
module posted_reg_bridge
  import pwb_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fclk_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  ready_o,
  output logic                  err_o,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [DATA_W-1:0]     capture_i,
  output logic [NCH*DATA_W-1:0] fregs_o,
  output logic [NCH-1:0]        fstb_o
);
  logic [NCH-1:0]    hit_sync, pend_w, launch_vec;
  logic [DATA_W-1:0] sh_w [NCH];
  logic [DATA_W-1:0] fd_w [NCH];
  logic              posted_q, np_busy_q, launch, sel_pend, accept, if_wr, srst_start, rst_done;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign hit_sync[i]   = (addr_i == ADDR_W'(CH_OFS[i]));
    assign launch_vec[i] = launch & hit_sync[i];
    pwb_chan #(.DATA_W(DATA_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fclk_i   (fclk_i),
      .launch_i (launch_vec[i]),
      .wdata_i  (wdata_i),
      .pend_o   (pend_w[i]),
      .shadow_o (sh_w[i]),
      .fdata_o  (fd_w[i]),
      .fstb_o   (fstb_o[i])
    );
    assign fregs_o[i*DATA_W +: DATA_W] = fd_w[i];
  end

  assign sel_pend = |(hit_sync & pend_w);

  always_comb begin
    ready_o = 1'b1;
    err_o   = 1'b0;
    launch  = 1'b0;
    if (req_i && |hit_sync) begin
      if (we_i) begin
        if (posted_q) begin
          if (sel_pend) err_o = 1'b1;
          else          launch = 1'b1;
        end else if (np_busy_q) begin
          ready_o = !sel_pend;
        end else begin
          ready_o = 1'b0;
          launch  = !sel_pend;
        end
      end else if (sel_pend) begin
        if (posted_q) err_o = 1'b1;
        else          ready_o = 1'b0;
      end
    end
  end

  assign accept     = req_i && ready_o;
  assign if_wr      = accept && we_i && (addr_i == ADDR_W'(OFS_IF));
  assign srst_start = if_wr && wdata_i[IF_SRST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      posted_q  <= 1'b1;
      np_busy_q <= 1'b0;
    end else begin
      if (if_wr) posted_q <= wdata_i[IF_SRST_BIT] | wdata_i[IF_POSTED_BIT];
      if (launch && !posted_q) np_busy_q <= 1'b1;
      else if (accept)         np_busy_q <= 1'b0;
    end
  end

  pwb_soft_rst #(.CYCLES(RST_CYCLES)) u_soft_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (srst_start),
    .done_o  (rst_done)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++) if (hit_sync[i]) rdata_o = sh_w[i];
    if (addr_i == ADDR_W'(OFS_SYS))  rdata_o = DATA_W'(rst_done);
    if (addr_i == ADDR_W'(OFS_PEND)) rdata_o = DATA_W'(pend_w);
    if (addr_i == ADDR_W'(OFS_CAP))  rdata_o = capture_i;
    if (addr_i == ADDR_W'(OFS_IF))   rdata_o = DATA_W'({posted_q, 2'b00});
  end

  AST_ERR_ONLY_POSTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> posted_q); // R6
  AST_ERR_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> req_i && ready_o); // R4
  AST_NP_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && !posted_q && (|(hit_sync & pend_w)) |-> !ready_o); // R6
  AST_POSTED_WRITE_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && posted_q |-> ready_o); // R2
endmodule

// File: tb/test_posted_reg_bridge.sv
`timescale 1ns/1ps
module test_posted_reg_bridge;
  localparam int DW = 32;
  localparam int RSTC = 16;

  logic clk = 1'b0, fclk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, capture = '0;
  logic ready, err;
  logic [5*DW-1:0] fregs;
  logic [4:0] fstb;

  always #10 clk = ~clk;
  always #35 fclk = ~fclk;

  posted_reg_bridge #(.DATA_W(DW), .ADDR_W(8), .RST_CYCLES(RSTC)) i_posted_reg_bridge (
    .clk_i(clk), .rst_ni(rst_n), .fclk_i(fclk), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .err_o(err), .rdata_o(rdata), .capture_i(capture),
    .fregs_o(fregs), .fstb_o(fstb));

  typedef struct { string tag; logic [DW-1:0] data; logic [DW-1:0] mask; bit err; } exp_t;
  typedef struct { logic [DW-1:0] data; bit err; } obs_t;
  exp_t exp_q[$];
  obs_t obs_q[$];
  int n_chk = 0, n_fail = 0;
  int stb_cnt [5] = '{0, 0, 0, 0, 0};
  bit done = 1'b0;

  task automatic chk(string tag, bit ok, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(negedge fclk) for (int i = 0; i < 5; i++) if (fstb[i]) stb_cnt[i]++;

  // monitor: pops one expectation per observed transfer
  initial forever begin
    obs_t o;
    exp_t e;
    wait (obs_q.size() != 0);
    o = obs_q.pop_front();
    e = exp_q.pop_front();
    chk(e.tag, ((o.data & e.mask) == (e.data & e.mask)) && (o.err == e.err),
        {o.err, o.data}, {e.err, e.data});
  end

  task automatic bus_raw(input bit w, input logic [7:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] rd, output bit er, output int waits);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; waits = 0;
    #5;
    while (!ready) begin
      @(negedge clk);
      #5;
      waits++;
    end
    rd = rdata; er = err;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic xfer(string tag, bit w, logic [7:0] a, logic [DW-1:0] d,
                      logic [DW-1:0] ed, logic [DW-1:0] em, bit ee, output int waits);
    exp_t e;
    obs_t o;
    logic [DW-1:0] rd;
    bit er;
    e.tag = tag; e.data = ed; e.mask = em; e.err = ee;
    exp_q.push_back(e);
    bus_raw(w, a, d, rd, er, waits);
    o.data = rd; o.err = er;
    obs_q.push_back(o);
  endtask

  task automatic wait_idle(string tag);
    logic [DW-1:0] rd;
    bit er;
    int w, n;
    n = 0;
    do begin
      bus_raw(1'b0, 8'h34, '0, rd, er, w);
      n++;
    end while (rd[4:0] != 5'b0 && n < 200);
    chk(tag, n < 200, n, 200);
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_test();
  end

  initial begin
    int w, n;
    logic [DW-1:0] rd;
    bit er;
    #45 rst_n = 1'b1;
    // R1 reset state
    xfer("R1 if ctrl", 0, 8'h40, 0, 32'h4, '1, 0, w);
    xfer("R1 pending", 0, 8'h34, 0, 32'h0, '1, 0, w);
    xfer("R1 sysstat", 0, 8'h14, 0, 32'h1, '1, 0, w);
    chk("R1 fregs zero", fregs == '0, fregs[31:0], 0);

    // R2 posted write, R5 read while pending, R4 lost write, R10 independence
    xfer("R2 ctrl write", 1, 8'h24, 32'h11, 0, 0, 0, w);
    chk("R2 no wait", w == 0, w, 0);
    xfer("R2 ctrl pending bit0", 0, 8'h34, 0, 32'h1, 32'h1, 0, w);
    xfer("R5 read pending ctrl", 0, 8'h24, 0, 0, 0, 1, w);
    xfer("R4 second ctrl write", 1, 8'h24, 32'h22, 0, 0, 1, w);
    chk("R4 no wait", w == 0, w, 0);
    xfer("R10 load write", 1, 8'h2C, 32'h55, 0, 0, 0, w);
    chk("R10 no wait", w == 0, w, 0);
    xfer("R2 load pending bit2", 0, 8'h34, 0, 32'h4, 32'h4, 0, w);
    wait_idle("R3 pending clears");
    #200;
    chk("R4 fctrl keeps first", fregs[0*DW +: DW] == 32'h11, fregs[0*DW +: DW], 32'h11);
    chk("R3 fload", fregs[2*DW +: DW] == 32'h55, fregs[2*DW +: DW], 32'h55);
    chk("R4 one ctrl strobe", stb_cnt[0] == 1, stb_cnt[0], 1);
    chk("R3 one load strobe", stb_cnt[2] == 1, stb_cnt[2], 1);
    xfer("R4 ctrl readback", 0, 8'h24, 0, 32'h11, '1, 0, w);

    // R3 remaining channels
    xfer("R3 counter write", 1, 8'h28, 32'hDEAD0001, 0, 0, 0, w);
    xfer("R3 trigger write", 1, 8'h30, 32'h0, 0, 0, 0, w);
    xfer("R3 match write", 1, 8'h38, 32'h00C0FFEE, 0, 0, 0, w);
    xfer("R2 match pending bit4", 0, 8'h34, 0, 32'h10, 32'h10, 0, w);
    wait_idle("R3 pending clears 2");
    #200;
    chk("R3 fcounter", fregs[1*DW +: DW] == 32'hDEAD0001, fregs[1*DW +: DW], 32'hDEAD0001);
    chk("R3 fmatch", fregs[4*DW +: DW] == 32'h00C0FFEE, fregs[4*DW +: DW], 32'h00C0FFEE);
    chk("R3 trigger strobe", stb_cnt[3] == 1, stb_cnt[3], 1);

    // R7 read-only pending register, if ctrl has no pending bit
    xfer("R7 write pending reg", 1, 8'h34, 32'h1F, 0, 0, 0, w);
    xfer("R7 pending unchanged", 0, 8'h34, 0, 32'h0, '1, 0, w);
    xfer("R7 if write", 1, 8'h40, 32'h4, 0, 0, 0, w);
    xfer("R7 no if pending", 0, 8'h34, 0, 32'h0, '1, 0, w);

    // R6 non-posted
    xfer("R6 select non-posted", 1, 8'h40, 32'h0, 0, 0, 0, w);
    xfer("R6 if reads 0", 0, 8'h40, 0, 32'h0, '1, 0, w);
    xfer("R6 load write stalls", 1, 8'h2C, 32'hABCD, 0, 0, 0, w);
    chk("R6 stall cycles", w >= 3, w, 3);
    xfer("R6 nothing pending", 0, 8'h34, 0, 32'h0, '1, 0, w);
    chk("R6 landed", fregs[2*DW +: DW] == 32'hABCD, fregs[2*DW +: DW], 32'hABCD);
    xfer("R6 load readback", 0, 8'h2C, 0, 32'hABCD, '1, 0, w);

    // R9 capture and unmapped
    capture = 32'hCAFE0001;
    xfer("R9 capture", 0, 8'h3C, 0, 32'hCAFE0001, '1, 0, w);
    xfer("R9 unmapped", 0, 8'h08, 0, 32'h0, '1, 0, w);

    // R8 soft reset
    xfer("R8 start soft reset", 1, 8'h40, 32'h2, 0, 0, 0, w);
    xfer("R8 sysstat busy", 0, 8'h14, 0, 32'h0, '1, 0, w);
    n = 0;
    do begin
      bus_raw(1'b0, 8'h14, '0, rd, er, w);
      n++;
    end while (rd[0] != 1'b1 && n < 100);
    chk("R8 done within window", n >= 2 && n <= RSTC, n, RSTC);
    xfer("R8 if back to posted", 0, 8'h40, 0, 32'h4, '1, 0, w);

    // R5 again on match after returning to posted mode
    xfer("R2 match write 2", 1, 8'h38, 32'h77, 0, 0, 0, w);
    xfer("R5 read pending match", 0, 8'h38, 0, 0, 0, 1, w);
    wait_idle("R3 pending clears 3");

    wait (obs_q.size() == 0);
    #1;
    finish_test();
  end
endmodule